// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This core keeps wall-clock time as a count of seconds. A one-per-second strobe from outside advances a 32-bit up-counter and, in the same cycle, a second 32-bit counter that runs downward. Software keeps the down-counter equal to the all-ones value minus the up-counter. Both counters sit in a small word-addressed register file with a single-cycle write strobe and a combinational read port.

Two match registers are compared against the up-counter on every cycle. An equal compare latches a sticky status flag that stays set until software writes a one to it. Each flag can raise the interrupt output. Each flag can also raise a power-on switch output, and that output can be forced high from the control register. A counter-halt bit lets software load both counters without a tick slipping in between the two writes. A soft-reset bit returns the time-keeping state to its reset values and clears itself afterwards. A free 32-bit key word survives soft reset, so boot code can tell whether the block has already been set up.

Top module: `rtc_seconds_core`

## Requirements
- R1: After hardware reset the up-counter reads 0, the down-counter reads 0xFFFFFFFF, both match registers read 0xFFFFFFFF, and control, status and key read 0. The irq and pwr_on outputs are 0.
- R2: The word index selects the register: 0 up-counter, 1 down-counter, 2 match0, 3 match1, 4 control, 5 status, 6 key. Index 7 reads 0. Control keeps only bits 0-4, 6 and 7 of a write, and bit 5 reads 0.
- R3: A cycle with sec_tick=1, control bit 6 clear and no soft reset pending adds 1 to the up-counter and subtracts 1 from the down-counter at that clock edge. Both counters wrap around.
- R4: While control bit 6 is set, both counters hold their values under ticks but still take writes. Counting resumes once the bit is cleared.
- R5: A write to a counter in the same cycle as a tick stores the written value, and the tick is lost for that counter.
- R6: In a cycle where the up-counter equals match0 (match1), status bit 0 (bit 1) is set at the next edge. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A compare that stays true sets the flag again.
- R7: Status bit 2 sets at the edge after a cycle in which a match compare hits while its switch enable is set (control bit 2 for match0, bit 3 for match1). It clears by writing 1.
- R8: irq is 1 exactly when (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R9: pwr_on is 1 exactly when control bit 7 is set, or when (status bit 0 AND control bit 2), or when (status bit 1 AND control bit 3).
- R10: Writing control bit 4 starts a soft reset. At the following edge the counters return to 0 and 0xFFFFFFFF, status bits 0 and 1 and every control bit (bit 4 included) clear, and counting is suppressed for that edge. The match registers and status bit 2 are kept.
- R11: The key register stores any 32-bit value and keeps it across soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| reg_wr | input | 1 | Write strobe for the register file |
| reg_word_addr | input | 3 | Register word index (byte offset = 4 x index) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt from enabled match flags |
| pwr_on | output | 1 | Power-on switch request |

## Verification
If a counter is wrong it shows on reg_rdata in the cycle the register is addressed. If a compare or flag is wrong, irq or pwr_on shows it one edge after the equality, when the matching enable bits are set. The bench runs a behavioural model of the register file in parallel and checks irq, pwr_on and the read port after every edge. A fault therefore shows up within a cycle of the first stimulus that exposes it, not only at the directed reads. The corner cases covered are tick-and-write collisions, the halted state, flags that re-arm while the compare holds, soft reset landing on a live match, and counter wrap.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
    localparam int CTRL_W = 8;
    localparam int STAT_W = 3;

    // control bit positions
    localparam int C_IRQ0  = 0;
    localparam int C_IRQ1  = 1;
    localparam int C_SW0   = 2;
    localparam int C_SW1   = 3;
    localparam int C_SRST  = 4;
    localparam int C_HALT  = 6;
    localparam int C_FORCE = 7;

    localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 8'hDF;

    typedef enum logic [2:0] {
        SEL_UP   = 3'd0,
        SEL_DN   = 3'd1,
        SEL_M0   = 3'd2,
        SEL_M1   = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_STAT = 3'd5,
        SEL_KEY  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/rtc_counter_pair.sv
module rtc_counter_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         restart,
    input  logic         up_we,
    input  logic         dn_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] up_cnt,
    output logic [W-1:0] dn_cnt
);
    typedef struct packed {
        logic [W-1:0] up;
        logic [W-1:0] dn;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            cnt_d.up = cnt_q.up + W'(1);
            cnt_d.dn = cnt_q.dn - W'(1);
        end
        if (up_we) cnt_d.up = wdata;
        if (dn_we) cnt_d.dn = wdata;
        if (restart) begin
            cnt_d.up = '0;
            cnt_d.dn = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.up <= '0;
            cnt_q.dn <= '1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign up_cnt = cnt_q.up;
    assign dn_cnt = cnt_q.dn;
endmodule

// File: rtl/rtc_match_flags.sv
module rtc_match_flags #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        count,
    input  logic [N-1:0][W-1:0] mval,
    input  logic [N-1:0]        sw_en,
    input  logic [N:0]          clr,
    input  logic                flush,
    output logic [N:0]          flags
);
    logic [N-1:0] hit;
    logic [N:0]   flag_d, flag_q;
    logic         sw_event;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (count == mval[i]);
    end

    always_comb begin
        sw_event = |(hit & sw_en);
        flag_d[N-1:0] = (flag_q[N-1:0] & ~clr[N-1:0]) | hit;
        flag_d[N]     = (flag_q[N] & ~clr[N]) | sw_event;
        if (flush) flag_d[N-1:0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_core_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_word_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              pwr_on
);
    localparam int NUM_MATCH = 2;

    typedef struct packed {
        logic [CTRL_W-1:0]                 ctrl;
        logic [NUM_MATCH-1:0][DATA_W-1:0]  mtch;
        logic [DATA_W-1:0]                 key;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    reg_sel_e            sel;
    logic                wr_up, wr_dn, wr_stat;
    logic [DATA_W-1:0]   up_cnt, dn_cnt;
    logic [STAT_W-1:0]   flags;
    logic [STAT_W-1:0]   stat_clr;
    logic                srst_now, halt_now, advance;
    logic [CTRL_W-1:0]   ctrl_cur;
    logic [DATA_W-1:0]   match0_cur;

    assign sel        = reg_sel_e'(reg_word_addr);
    assign ctrl_cur   = cfg_q.ctrl;
    assign match0_cur = cfg_q.mtch[0];
    assign srst_now   = cfg_q.ctrl[C_SRST];
    assign halt_now   = cfg_q.ctrl[C_HALT];

    always_comb begin
        wr_up    = reg_wr && (sel == SEL_UP);
        wr_dn    = reg_wr && (sel == SEL_DN);
        wr_stat  = reg_wr && (sel == SEL_STAT);
        stat_clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
        advance  = sec_tick && !halt_now && !srst_now;
    end

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && sel == SEL_CTRL) cfg_d.ctrl = reg_wdata[CTRL_W-1:0] & CTRL_WR_MASK;
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (reg_wr && (int'(sel) == int'(SEL_M0) + i)) cfg_d.mtch[i] = reg_wdata;
        end
        if (reg_wr && sel == SEL_KEY) cfg_d.key = reg_wdata;
        if (srst_now) cfg_d.ctrl = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ctrl <= '0;
            cfg_q.mtch <= '1;
            cfg_q.key  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    rtc_counter_pair #(.W(DATA_W)) i_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .restart (srst_now),
        .up_we   (wr_up),
        .dn_we   (wr_dn),
        .wdata   (reg_wdata),
        .up_cnt  (up_cnt),
        .dn_cnt  (dn_cnt)
    );

    rtc_match_flags #(.W(DATA_W), .N(NUM_MATCH)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .count (up_cnt),
        .mval  (cfg_q.mtch),
        .sw_en (cfg_q.ctrl[C_SW1:C_SW0]),
        .clr   (stat_clr),
        .flush (srst_now),
        .flags (flags)
    );

    // read port and outputs
    always_comb begin
        unique case (sel)
            SEL_UP:   reg_rdata = up_cnt;
            SEL_DN:   reg_rdata = dn_cnt;
            SEL_M0:   reg_rdata = cfg_q.mtch[0];
            SEL_M1:   reg_rdata = cfg_q.mtch[1];
            SEL_CTRL: reg_rdata = DATA_W'(cfg_q.ctrl);
            SEL_STAT: reg_rdata = DATA_W'(flags);
            SEL_KEY:  reg_rdata = cfg_q.key;
            default:  reg_rdata = '0;
        endcase
        irq    = |(flags[1:0] & cfg_q.ctrl[C_IRQ1:C_IRQ0]);
        pwr_on = cfg_q.ctrl[C_FORCE] | |(flags[1:0] & cfg_q.ctrl[C_SW1:C_SW0]);
    end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              reg_wr,
    input logic [IDX_W-1:0]  reg_word_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] up_cnt,
    input logic [DATA_W-1:0] dn_cnt,
    input logic [DATA_W-1:0] match0_cur,
    input logic [7:0]        ctrl_cur,
    input logic [2:0]        flags,
    input logic              irq,
    input logic              pwr_on
);
    logic clr0_wr;
    assign clr0_wr = reg_wr && (reg_word_addr == IDX_W'(5)) && reg_wdata[0];

    assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !ctrl_cur[6] && !ctrl_cur[4] && !reg_wr)
        |=> (up_cnt == $past(up_cnt) + DATA_W'(1)) && (dn_cnt == $past(dn_cnt) - DATA_W'(1)));

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cur[6] && !ctrl_cur[4] && !reg_wr) |=> $stable(up_cnt) && $stable(dn_cnt));

    assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word_addr == IDX_W'(0) && sec_tick && !ctrl_cur[4])
        |=> up_cnt == $past(reg_wdata));

    assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == match0_cur && !ctrl_cur[4]) |=> flags[0]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !ctrl_cur[4] && !clr0_wr) |=> flags[0]);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cur[1:0] == 2'b00) |-> !irq);

    assert_force_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_cur[7] |-> pwr_on);

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_cur[4] |=> (ctrl_cur == 8'h00) && (up_cnt == '0) && (dn_cnt == '1) && (flags[1:0] == 2'b00));
endmodule

bind rtc_seconds_core rtc_core_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_rtc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .reg_wr        (reg_wr),
    .reg_word_addr (reg_word_addr),
    .reg_wdata     (reg_wdata),
    .up_cnt        (up_cnt),
    .dn_cnt        (dn_cnt),
    .match0_cur    (match0_cur),
    .ctrl_cur      (ctrl_cur),
    .flags         (flags),
    .irq           (irq),
    .pwr_on        (pwr_on)
);

// File: tb/test_rtc_seconds_core.sv
module test_rtc_seconds_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_word_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, pwr_on;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_seconds_core i_rtc_seconds_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
        .reg_word_addr(reg_word_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .pwr_on(pwr_on)
    );

    // behavioural reference state
    logic [31:0] m_up, m_dn, m_m0, m_m1, m_key;
    logic [7:0]  m_ctrl;
    logic [2:0]  m_st;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_up;
            3'd1: return m_dn;
            3'd2: return m_m0;
            3'd3: return m_m1;
            3'd4: return {24'd0, m_ctrl};
            3'd5: return {29'd0, m_st};
            3'd6: return m_key;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_up = 0; m_dn = 32'hFFFFFFFF; m_m0 = 32'hFFFFFFFF; m_m1 = 32'hFFFFFFFF;
            m_key = 0; m_ctrl = 0; m_st = 0;
        end else begin : step
            bit h0, h1, rs;
            logic [7:0] c_old;
            h0 = (m_up == m_m0);
            h1 = (m_up == m_m1);
            rs = m_ctrl[4];
            c_old = m_ctrl;
            if (sec_tick && !m_ctrl[6] && !rs) begin
                m_up = m_up + 1;
                m_dn = m_dn - 1;
            end
            if (reg_wr) begin
                case (reg_word_addr)
                    3'd0: m_up = reg_wdata;
                    3'd1: m_dn = reg_wdata;
                    3'd2: m_m0 = reg_wdata;
                    3'd3: m_m1 = reg_wdata;
                    3'd4: m_ctrl = reg_wdata[7:0] & 8'hDF;
                    3'd5: m_st = m_st & ~reg_wdata[2:0];
                    3'd6: m_key = reg_wdata;
                    default: ;
                endcase
            end
            if (h0) m_st[0] = 1'b1;
            if (h1) m_st[1] = 1'b1;
            if ((h0 && c_old[2]) || (h1 && c_old[3])) m_st[2] = 1'b1;
            if (rs) begin
                m_up = 0; m_dn = 32'hFFFFFFFF; m_ctrl = 0; m_st[1:0] = 2'b00;
            end
        end
        #1;
        if (rst_n && !done) begin
            check("R8 irq vs model", {31'd0, irq},
                  {31'd0, (m_st[0] & m_ctrl[0]) | (m_st[1] & m_ctrl[1])});
            check("R9 pwr_on vs model", {31'd0, pwr_on},
                  {31'd0, m_ctrl[7] | (m_st[0] & m_ctrl[2]) | (m_st[1] & m_ctrl[3])});
            check("R2 rdata vs model", reg_rdata, m_read(reg_word_addr));
        end
    end

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        reg_wr = 1'b1; reg_word_addr = a; reg_wdata = d; sec_tick = t;
        @(negedge clk);
        reg_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_word_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 up after reset");
        rd(3'd1, 32'hFFFFFFFF, "R1 down after reset");
        rd(3'd2, 32'hFFFFFFFF, "R1 match0 after reset");
        rd(3'd3, 32'hFFFFFFFF, "R1 match1 after reset");
        rd(3'd4, 32'h0, "R1 control after reset");
        rd(3'd5, 32'h0, "R1 status after reset");
        rd(3'd6, 32'h0, "R1 key after reset");
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 pwr_on after reset", {31'd0, pwr_on}, 32'd0);
        rd(3'd7, 32'h0, "R2 unmapped index");
        // R11 key
        do_wr(3'd6, 32'hB5C13F27, 1'b0);
        rd(3'd6, 32'hB5C13F27, "R11 key readback");
        // R2 control mask, R9 force
        do_wr(3'd4, 32'h000000EF, 1'b0);
        rd(3'd4, 32'h000000CF, "R2 control write mask");
        check("R9 forced pwr_on", {31'd0, pwr_on}, 32'd1);
        check("R8 irq without flags", {31'd0, irq}, 32'd0);
        do_wr(3'd4, 32'h0, 1'b0);
        // R3 counting
        do_tick(5);
        rd(3'd0, 32'd5, "R3 up after 5 ticks");
        rd(3'd1, 32'hFFFFFFFA, "R3 down after 5 ticks");
        // R4 halt
        do_wr(3'd4, 32'h40, 1'b0);
        do_tick(3);
        rd(3'd0, 32'd5, "R4 up held while halted");
        do_wr(3'd0, 32'd100, 1'b0);
        do_wr(3'd1, 32'hFFFFFF9B, 1'b0);
        do_tick(2);
        rd(3'd0, 32'd100, "R4 up loaded while halted");
        rd(3'd1, 32'hFFFFFF9B, "R4 down loaded while halted");
        do_wr(3'd4, 32'h0, 1'b0);
        do_tick(1);
        rd(3'd0, 32'd101, "R4 counting resumes");
        rd(3'd1, 32'hFFFFFF9A, "R3 down follows");
        // R5 write beats tick
        do_wr(3'd0, 32'h200, 1'b1);
        rd(3'd0, 32'h200, "R5 write wins over tick");
        rd(3'd1, 32'hFFFFFF99, "R5 down still ticks");
        // R6 / R8 match0 interrupt
        do_wr(3'd2, 32'h203, 1'b0);
        do_wr(3'd4, 32'h01, 1'b0);
        do_tick(3);
        idle(1);
        rd(3'd5, 32'h1, "R6 match0 flag set");
        check("R8 irq on match0", {31'd0, irq}, 32'd1);
        do_wr(3'd5, 32'h0, 1'b0);
        rd(3'd5, 32'h1, "R6 write zero keeps flag");
        do_wr(3'd5, 32'h1, 1'b0);
        rd(3'd5, 32'h1, "R6 flag re-arms while equal");
        do_wr(3'd2, 32'hFFFFFFFF, 1'b0);
        do_wr(3'd5, 32'h1, 1'b0);
        rd(3'd5, 32'h0, "R6 flag cleared by W1C");
        check("R8 irq drops", {31'd0, irq}, 32'd0);
        // R7 / R9 match1 switch
        do_wr(3'd3, 32'h205, 1'b0);
        do_wr(3'd4, 32'h08, 1'b0);
        do_tick(2);
        idle(1);
        rd(3'd5, 32'h6, "R7 switch event latched");
        check("R9 pwr_on from match1", {31'd0, pwr_on}, 32'd1);
        check("R8 irq off when not enabled", {31'd0, irq}, 32'd0);
        do_wr(3'd3, 32'hFFFFFFFF, 1'b0);
        do_wr(3'd5, 32'h7, 1'b0);
        rd(3'd5, 32'h0, "R7 status cleared");
        check("R9 pwr_on released", {31'd0, pwr_on}, 32'd0);
        // R10 soft reset over a live match
        do_wr(3'd4, 32'h04, 1'b0);
        do_wr(3'd2, 32'h205, 1'b0);
        do_wr(3'd4, 32'h10, 1'b0);
        idle(1);
        rd(3'd0, 32'h0, "R10 up restarted");
        rd(3'd1, 32'hFFFFFFFF, "R10 down restarted");
        rd(3'd4, 32'h0, "R10 control cleared");
        rd(3'd5, 32'h4, "R10 match flags cleared, bit2 kept");
        rd(3'd2, 32'h205, "R10 match0 kept");
        rd(3'd6, 32'hB5C13F27, "R11 key kept over soft reset");
        // R3 wrap
        do_wr(3'd0, 32'hFFFFFFFF, 1'b0);
        do_wr(3'd1, 32'h0, 1'b0);
        do_tick(1);
        rd(3'd0, 32'h0, "R3 up wraps");
        rd(3'd1, 32'hFFFFFFFF, "R3 down wraps");
        idle(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule